// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block resolves the operand of a load-class instruction and hands the final byte to an accumulator datapath. On a start strobe it captures a 3-bit mode code, a 4-bit operand field, two 8-bit base registers and the program counter. It then reads a byte-wide synchronous memory zero, one or two times, depending on the mode, to produce the operand value.

Six modes are supported. In immediate mode the field is the value. In direct mode the field is the address. In memory-indirect mode the field points at a byte that holds the address. In register-indirect mode a base register holds the address. In indexed mode the address is base register B plus the field. In PC-relative mode the address is the program counter plus the sign-extended field. All address arithmetic wraps modulo 256.

A small sequencer sets the cost of each mode. The immediate and invalid-code paths finish one cycle after the start cycle, single-read modes after two, and the pointer-chasing mode after three. A one-cycle `done_o` pulse marks the cycle in which the value, the effective address and the error flag are valid.

Top module: `opf_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the 4-bit field zero-extended to 8 bits, with no memory read. `ea_valid_o` is low and `done_o` pulses one cycle after the start cycle.
- R2: Mode code 1 (direct) makes exactly one read at the zero-extended field. It returns that byte with `ea_o` equal to the field, and `done_o` pulses two cycles after the start cycle.
- R3: Mode code 2 (memory-indirect) first reads at the zero-extended field, then reads at the byte returned. `ea_o` is that pointer byte and the value is the second read. Exactly two reads are made, and `done_o` pulses three cycles after the start cycle.
- R4: Mode code 3 (register-indirect) uses base register A as the address when field bit 0 is 0, and base register B when it is 1. It makes one read, and `done_o` pulses two cycles after the start cycle.
- R5: Mode code 4 (indexed) uses base register B plus the zero-extended field, modulo 256, as the address (B=10, field 4 gives 14). It makes one read, and `done_o` pulses two cycles after the start cycle.
- R6: Mode code 5 (PC-relative) uses the program counter plus the field taken as signed 4-bit, modulo 256, as the address. It makes one read, and `done_o` pulses two cycles after the start cycle.
- R7: Mode codes 6 and 7 make no read. `done_o` and `err_o` pulse together one cycle after the start cycle, with `value_o` equal to 0 and `ea_valid_o` low. `err_o` is low in every other cycle.
- R8: A start strobe that arrives while `busy_o` is high has no effect: the running operation's result and timing are unchanged, and no extra done pulse follows. Changes to inputs after the start cycle do not affect the result.
- R9: `done_o` is high for exactly one cycle per accepted start, and the unit is idle in the cycle after it. For memory modes, `ea_valid_o` is high with `done_o`, and `ea_o` equals the address of the final read.
- R10: While reset is high, and in the first cycle after it, `busy_o`, `done_o` and `mem_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mode_i | input | 3 | Addressing mode code |
| field_i | input | 4 | Operand field of the instruction |
| reg_a_i | input | 8 | Base register A |
| reg_b_i | input | 8 | Base register B |
| pc_i | input | 8 | Program counter |
| busy_o | output | 1 | Operation in progress, including its done cycle |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 8 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| ea_o | output | 8 | Effective address, valid with done |
| ea_valid_o | output | 1 | Effective address meaningful (memory modes) |
| value_o | output | 8 | Fetched operand, valid with done |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Unknown mode code, valid with done |

## Verification
The assertions check, on every cycle, the address driven in the first cycle after each accepted start for every mode. For the pointer mode they also check that the second request follows the returned byte. They further cover the immediate and error results, the single-cycle done pulse, and the agreement of `ea_o` with the last request. Only the bench can show the end-to-end values returned through a live memory, the exact read counts and latencies per mode, and wrap-around of indexed and PC-relative addresses. It likewise shows that a start strobe held high through a busy operation, or inputs changed after capture, leave the result and the completion timing untouched.

// File: rtl/opf_pkg.sv
package opf_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FIELD_W = 4;
    localparam int MODE_W  = 3;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM   = 3'd0,
        AM_DIR   = 3'd1,
        AM_MIND  = 3'd2,
        AM_RIND  = 3'd3,
        AM_IDX   = 3'd4,
        AM_PCREL = 3'd5,
        AM_RSV6  = 3'd6,
        AM_RSV7  = 3'd7
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_FETCH,
        ST_CHASE,
        ST_RESP,
        ST_LOCAL
    } state_e;

    typedef struct packed {
        amode_e mode;
        field_t field;
        addr_t  reg_a;
        addr_t  reg_b;
        addr_t  pc;
    } req_t;

    function automatic logic mode_known(amode_e m);
        return m <= AM_PCREL;
    endfunction

    function automatic addr_t zext(field_t f);
        return addr_t'(f);
    endfunction

    function automatic addr_t sext(field_t f);
        return {{(ADDR_W-FIELD_W){f[FIELD_W-1]}}, f};
    endfunction

    function automatic logic [1:0] reads_for(amode_e m);
        if (!mode_known(m) || m == AM_IMM) return 2'd0;
        if (m == AM_MIND)                  return 2'd2;
        return 2'd1;
    endfunction

endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
    import opf_pkg::*;
(
    input  req_t  req,
    output addr_t ptr_addr,
    output addr_t ea
);
    always_comb begin
        ptr_addr = zext(req.field);
        unique case (req.mode)
            AM_DIR:   ea = zext(req.field);
            AM_RIND:  ea = req.field[0] ? req.reg_b : req.reg_a;
            AM_IDX:   ea = req.reg_b + zext(req.field);
            AM_PCREL: ea = req.pc + sext(req.field);
            default:  ea = '0;
        endcase
    end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
    import opf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  amode_e mode_i,
    output state_e state_o,
    output logic   accept_o
);
    state_e state_q, state_d;

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign state_o  = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    unique case (reads_for(mode_i))
                        2'd0:    state_d = ST_LOCAL;
                        2'd2:    state_d = ST_PTR;
                        default: state_d = ST_FETCH;
                    endcase
                end
            end
            ST_PTR:   state_d = ST_CHASE;
            ST_FETCH: state_d = ST_RESP;
            ST_CHASE: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_LOCAL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/opf_unit.sv
module opf_unit
    import opf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [FIELD_W-1:0]  field_i,
    input  logic [ADDR_W-1:0]   reg_a_i,
    input  logic [ADDR_W-1:0]   reg_b_i,
    input  logic [ADDR_W-1:0]   pc_i,
    output logic                busy_o,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic [ADDR_W-1:0]   ea_o,
    output logic                ea_valid_o,
    output logic [DATA_W-1:0]   value_o,
    output logic                done_o,
    output logic                err_o
);
    state_e state;
    logic   accept;
    req_t   req_q;
    addr_t  ptr_addr, calc_ea, ea_q;
    data_t  res_q;
    logic   err_q;
    amode_e mode_in;

    assign mode_in = amode_e'(mode_i);

    opf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .mode_i   (mode_in),
        .state_o  (state),
        .accept_o (accept)
    );

    opf_ea_calc u_ea (
        .req      (req_q),
        .ptr_addr (ptr_addr),
        .ea       (calc_ea)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            ea_q  <= '0;
            res_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (accept) begin
                req_q.mode  <= mode_in;
                req_q.field <= field_i;
                req_q.reg_a <= reg_a_i;
                req_q.reg_b <= reg_b_i;
                req_q.pc    <= pc_i;
                err_q       <= !mode_known(mode_in);
                if (reads_for(mode_in) == 2'd0) begin
                    ea_q  <= '0;
                    res_q <= (mode_in == AM_IMM) ? data_t'(field_i) : '0;
                end
            end
            unique case (state)
                ST_FETCH: ea_q  <= calc_ea;
                ST_CHASE: ea_q  <= addr_t'(mem_rdata_i);
                ST_RESP:  res_q <= mem_rdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd_o   = 1'b0;
        mem_addr_o = '0;
        unique case (state)
            ST_PTR:   begin mem_rd_o = 1'b1; mem_addr_o = ptr_addr;              end
            ST_FETCH: begin mem_rd_o = 1'b1; mem_addr_o = calc_ea;               end
            ST_CHASE: begin mem_rd_o = 1'b1; mem_addr_o = addr_t'(mem_rdata_i);  end
            default: ;
        endcase
    end

    assign busy_o     = (state != ST_IDLE);
    assign done_o     = (state == ST_RESP) || (state == ST_LOCAL);
    assign ea_valid_o = (state == ST_RESP);
    assign ea_o       = ea_q;
    assign value_o    = (state == ST_RESP) ? mem_rdata_i : res_q;
    assign err_o      = (state == ST_LOCAL) && err_q;

endmodule

// File: rtl/opf_checker.sv
module opf_checker
    import opf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [MODE_W-1:0]   mode_i,
    input logic [FIELD_W-1:0]  field_i,
    input logic [ADDR_W-1:0]   reg_a_i,
    input logic [ADDR_W-1:0]   reg_b_i,
    input logic [ADDR_W-1:0]   pc_i,
    input logic                busy_o,
    input logic                mem_rd_o,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic [DATA_W-1:0]   mem_rdata_i,
    input logic [ADDR_W-1:0]   ea_o,
    input logic                ea_valid_o,
    input logic [DATA_W-1:0]   value_o,
    input logic                done_o,
    input logic                err_o
);
    logic go;
    assign go = start_i && !busy_o;

    AST_IMM_RESULT: assert property (@(posedge clk) disable iff (rst)
        go && mode_i == 3'd0 |=> done_o && !mem_rd_o && !ea_valid_o && !err_o
                                 && value_o == DATA_W'($past(field_i)));  // R1
    AST_DIR_ADDR: assert property (@(posedge clk) disable iff (rst)
        go && mode_i == 3'd1 |=> mem_rd_o && mem_addr_o == ADDR_W'($past(field_i)));  // R2
    AST_MIND_CHAIN: assert property (@(posedge clk) disable iff (rst)
        go && mode_i == 3'd2 |=> mem_rd_o && mem_addr_o == ADDR_W'($past(field_i))
                                 ##1 mem_rd_o && mem_addr_o == ADDR_W'(mem_rdata_i));  // R3
    AST_RIND_ADDR: assert property (@(posedge clk) disable iff (rst)
        go && mode_i == 3'd3 |=> mem_rd_o
            && mem_addr_o == ($past(field_i[0]) ? $past(reg_b_i) : $past(reg_a_i)));  // R4
    AST_IDX_ADDR: assert property (@(posedge clk) disable iff (rst)
        go && mode_i == 3'd4 |=> mem_rd_o
            && mem_addr_o == ADDR_W'($past(reg_b_i) + ADDR_W'($past(field_i))));  // R5
    AST_PCREL_ADDR: assert property (@(posedge clk) disable iff (rst)
        go && mode_i == 3'd5 |=> mem_rd_o
            && mem_addr_o == ADDR_W'($past(pc_i) + sext($past(field_i))));  // R6
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
        go && mode_i > 3'd5 |=> done_o && err_o && !mem_rd_o && !ea_valid_o
                                && value_o == '0);  // R7
    AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);  // R7
    AST_DONE_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o && !done_o);  // R8
    AST_DONE_EA: assert property (@(posedge clk) disable iff (rst)
        done_o && ea_valid_o |-> $past(mem_rd_o) && ea_o == $past(mem_addr_o));  // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !busy_o && !done_o && !mem_rd_o);  // R10
endmodule

bind opf_unit opf_checker u_chk (.*);

// File: tb/tb_opf_unit.sv
module tb_opf_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] mode_i = '0;
    logic [3:0] field_i = '0;
    logic [7:0] reg_a_i = '0, reg_b_i = '0, pc_i = '0;
    logic       busy_o, mem_rd_o, ea_valid_o, done_o, err_o;
    logic [7:0] mem_addr_o, ea_o, value_o;
    logic [7:0] mem_rdata_i = '0;
    logic [7:0] mem [256];

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    opf_unit dut (.*);

    always @(posedge clk)
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model(input logic [2:0] m, input logic [3:0] f,
                         input logic [7:0] a, input logic [7:0] b, input logic [7:0] p,
                         output logic [7:0] val, output logic [7:0] ea,
                         output int lat, output int rds, output bit err);
        err = 0; ea = 0; val = 0; lat = 2; rds = 1;
        case (m)
            3'd0: begin val = {4'd0, f}; lat = 1; rds = 0; end
            3'd1: ea = {4'd0, f};
            3'd2: begin ea = mem[{4'd0, f}]; lat = 3; rds = 2; end
            3'd3: ea = f[0] ? b : a;
            3'd4: ea = b + {4'd0, f};
            3'd5: ea = p + {{4{f[3]}}, f};
            default: begin err = 1; lat = 1; rds = 0; end
        endcase
        if (rds != 0) val = mem[ea];
    endtask

    task automatic run_op(input logic [2:0] m, input logic [3:0] f,
                          input logic [7:0] a, input logic [7:0] b, input logic [7:0] p,
                          input bit hammer);
        logic [7:0] e_val, e_ea, g_val, g_ea;
        int e_lat, e_rds, n, rds;
        bit e_err, got, g_err, g_eav;
        string t;
        t = tag_of(m);
        model(m, f, a, b, p, e_val, e_ea, e_lat, e_rds, e_err);
        @(negedge clk);
        start_i = 1; mode_i = m; field_i = f; reg_a_i = a; reg_b_i = b; pc_i = p;
        n = 0; rds = 0; got = 0; g_val = 0; g_ea = 0; g_err = 0; g_eav = 0;
        while (!got && n < 8) begin
            @(negedge clk);
            n++;
            if (mem_rd_o) rds++;
            if (done_o) begin
                got = 1; g_val = value_o; g_ea = ea_o; g_err = err_o; g_eav = ea_valid_o;
            end
            start_i = hammer;
            mode_i = 3'($urandom); field_i = 4'($urandom);
            reg_a_i = 8'($urandom); reg_b_i = 8'($urandom); pc_i = 8'($urandom);
        end
        start_i = 0;
        chk(got && n == e_lat, {t, " latency (R9)"}, n, e_lat);
        chk(g_val == e_val, {t, " value"}, g_val, e_val);
        chk(rds == e_rds, {t, " read count"}, rds, e_rds);
        chk(g_err == e_err, {t, " error flag (R7)"}, g_err, e_err);
        chk(g_eav == (e_rds != 0), {t, " ea_valid (R9)"}, g_eav, e_rds != 0);
        if (e_rds != 0) chk(g_ea == e_ea, {t, " effective address"}, g_ea, e_ea);
        if (hammer) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!done_o && !busy_o, "R8 no extra op after busy start", done_o, 0);
            end
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        mem[14] = 8'd42; mem[5] = 8'd14; mem[10] = 8'd77; mem[3] = 8'd99; mem[250] = 8'd5;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_rd_o, "R10 in reset", busy_o, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_rd_o, "R10 after reset", busy_o, 0);

        // directed: shared reference memory, all memory modes give 42
        run_op(3'd0, 4'd14, 8'd14, 8'd10, 8'd0, 0);   // R1 -> 14
        run_op(3'd1, 4'd14, 8'd14, 8'd10, 8'd0, 0);   // R2
        run_op(3'd2, 4'd5,  8'd14, 8'd10, 8'd0, 0);   // R3
        run_op(3'd3, 4'd0,  8'd14, 8'd10, 8'd0, 0);   // R4 register A
        run_op(3'd3, 4'd1,  8'd14, 8'd10, 8'd0, 0);   // R4 register B -> 77
        run_op(3'd4, 4'd4,  8'd14, 8'd10, 8'd0, 0);   // R5 10+4
        run_op(3'd5, 4'hE,  8'd0,  8'd0,  8'd16, 0);  // R6 16-2
        run_op(3'd4, 4'd9,  8'd0,  8'd250, 8'd0, 0);  // R5 wrap to 3
        run_op(3'd5, 4'h8,  8'd0,  8'd0,  8'd2, 0);   // R6 2-8 wraps to 250
        run_op(3'd6, 4'd3,  8'd1,  8'd2,  8'd3, 0);   // R7
        run_op(3'd7, 4'hF,  8'd1,  8'd2,  8'd3, 0);   // R7
        run_op(3'd2, 4'd5,  8'd14, 8'd10, 8'd0, 1);   // R8 start held while busy
        run_op(3'd0, 4'd9,  8'd0,  8'd0,  8'd0, 1);   // R8 on immediate

        // constrained random
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 400; i++)
            run_op(3'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), ($urandom % 5) == 0);

        summary();
        $finish;
    end
endmodule